// File: doc/BRIEF.md
# Run-Length-Limited (2,7) Sector Header Serializer

This block builds the channel-bit stream that opens a disk sector and shifts it out one bit per clock-enable tick as a write-pulse stream. A start strobe loads two 8-bit counts. The block then emits that many gap fill bytes (0x33), that many preamble bytes (0xFF), one sync byte (0x62) and one address mark byte (0xFE). After these it passes the payload bytes that arrive over a byte-wide valid/ready handshake.

Every byte goes through a variable-length (2,7) run-length-limited code. Data bits are parsed MSB first, and code words that are not yet complete carry across byte boundaries. After the last payload byte, the open code word is completed with zero data bits. When its final channel bit has been shifted out, the block raises a one-cycle completion pulse.

Top module: `rll27_hdr_enc`

## Requirements
- R1: After a start strobe, the stream begins with `gap_len` gap bytes of value 0x33. Each one encodes to the 16 channel bits 0000100000001000. A `gap_len` of 0 emits no gap.
- R2: After the gap come `pre_len` preamble bytes of value 0xFF. Each one encodes to 1000100010001000. A `pre_len` of 0 emits no preamble.
- R3: After the preamble comes the sync byte 0x62, encoded as 0010000001000100.
- R4: After the sync byte comes the mark byte 0xFE, encoded as 1000100010000100.
- R5: Data bits are parsed MSB first, with words spanning byte boundaries, using this table: 10→0100, 11→1000, 000→000100, 010→100100, 011→001000, 0010→00100100, 0011→00001000. `wr_pulse` carries the channel bit, 1 = pulse.
- R6: Between any two pulses of a frame there are at least 2 and at most 7 zero bits.
- R7: After the byte marked by `s_last`, missing data bits of the open word are taken as 0. `done` is high for exactly one cycle after the last channel bit. In that cycle `busy`, `ch_valid` and `s_ready` are low, and `s_ready` stays low after the last byte is taken.
- R8: A bit is consumed on a rising edge with `ce` and `ch_valid` both high. While `ce` is low, the current bit and `ch_valid` hold. If payload is late, `ch_valid` drops and no bit is lost or repeated.
- R9: A start strobe while `busy` is high has no effect; the counts latched at the first start stay in force.
- R10: During and after reset, `busy`, `ch_valid`, `s_ready`, `done` and `wr_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Channel bit tick |
| start | input | 1 | Begins a frame when idle |
| gap_len | input | 8 | Number of gap bytes |
| pre_len | input | 8 | Number of preamble bytes |
| s_data | input | 8 | Payload byte |
| s_valid | input | 1 | Payload byte offered |
| s_last | input | 1 | Offered byte is the final one |
| s_ready | output | 1 | Payload byte accepted this edge if valid |
| wr_pulse | output | 1 | Current channel bit (pulse level) |
| ch_valid | output | 1 | `wr_pulse` holds a real channel bit |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The run-length assertions take it for granted that every frame is one continuous code stream. They count zeros only from the first pulse of a frame and rely on the window never emptying in the middle of a code word. The handshake and hold assertions take it for granted that `s_valid` stays up with stable data until taken, and that `start` is not raised in the cycle `done` ends a frame. The stimulus keeps within these: it holds each offered byte until the handshake, draws `ce` and valid gaps at random rates, and places the mid-frame restart strobe early in the frame.

// File: rtl/rll27_pkg.sv
package rll27_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GAP,
      ST_PRE,
      ST_SYNC,
      ST_MARK,
      ST_PAY,
      ST_FLUSH
   } frame_st_t;

   // one decoded code word: data bits used, channel bits left-aligned, channel length
   typedef struct packed {
      logic       ok;
      logic [2:0] dlen;
      logic [7:0] cw;
      logic [3:0] clen;
   } rll_word_t;

   // w holds the next four data bits (MSB first); bits past avail are zero
   function automatic rll_word_t rll_lookup(input logic [3:0] w,
                                            input logic [2:0] avail,
                                            input logic       flush);
      rll_word_t r;
      r = '0;
      if (w[3]) begin
         r.dlen = 3'd2;
         r.clen = 4'd4;
         r.cw   = w[2] ? 8'b1000_0000 : 8'b0100_0000;
      end else if (w[2:1] == 2'b01) begin
         r.dlen = 3'd4;
         r.clen = 4'd8;
         r.cw   = w[0] ? 8'b0000_1000 : 8'b0010_0100;
      end else begin
         r.dlen = 3'd3;
         r.clen = 4'd6;
         case (w[2:1])
            2'b00:   r.cw = 8'b0001_0000;
            2'b10:   r.cw = 8'b1001_0000;
            default: r.cw = 8'b0010_0000;
         endcase
      end
      r.ok = (avail >= r.dlen) || (flush && (avail != 3'd0));
      return r;
   endfunction

endpackage

// File: rtl/rll27_codec.sv
module rll27_codec
   import rll27_pkg::*;
#(
   parameter int SYM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic             flush,
   input  logic             take,
   input  logic [SYM_W-1:0] src_byte,
   output logic             room,
   output logic             cbit,
   output logic             ch_valid,
   output logic             idle
);
   localparam int SLACK  = 3;               // longest unfinished word carried over
   localparam int WIN_W  = SYM_W + SLACK;
   localparam int WCNT_W = $clog2(WIN_W + 1);
   localparam int CW_W   = 8;
   localparam int OCNT_W = $clog2(CW_W + 1);

   logic [WIN_W-1:0]  win_q, win_nx;
   logic [WCNT_W-1:0] wcnt_q, wcnt_nx, used, rem;
   logic [CW_W-1:0]   obuf_q;
   logic [OCNT_W-1:0] ocnt_q;
   logic [2:0]        avail;
   logic              need_word, load;
   rll_word_t         look;

   assign avail = (wcnt_q >= WCNT_W'(4)) ? 3'd4 : wcnt_q[2:0];
   assign look  = rll_lookup(win_q[WIN_W-1 -: 4], avail, flush);

   assign need_word = (ocnt_q == '0) || (ce && (ocnt_q == OCNT_W'(1)));
   assign load      = need_word && look.ok;

   always_comb begin
      used = '0;
      if (load) used = (WCNT_W'(look.dlen) > wcnt_q) ? wcnt_q : WCNT_W'(look.dlen);
   end

   assign rem  = wcnt_q - used;
   assign room = (rem <= WCNT_W'(SLACK));

   always_comb begin
      win_nx  = win_q << (load ? look.dlen : 3'd0);
      wcnt_nx = rem;
      if (take) begin
         win_nx  = win_nx | ({src_byte, {SLACK{1'b0}}} >> rem);
         wcnt_nx = rem + WCNT_W'(SYM_W);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         wcnt_q <= '0;
         obuf_q <= '0;
         ocnt_q <= '0;
      end else begin
         win_q  <= win_nx;
         wcnt_q <= wcnt_nx;
         if (load) begin
            obuf_q <= look.cw;
            ocnt_q <= OCNT_W'(look.clen);
         end else if (ce && (ocnt_q != '0)) begin
            obuf_q <= {obuf_q[CW_W-2:0], 1'b0};
            ocnt_q <= ocnt_q - OCNT_W'(1);
         end
      end
   end

   assign cbit     = obuf_q[CW_W-1];
   assign ch_valid = (ocnt_q != '0);
   assign idle     = (wcnt_q == '0) && (ocnt_q == '0);

   // zero-run tracker feeding the run-length checks
   logic [3:0] zrun_q;
   logic       seen_q;
   logic       emit;
   assign emit = ce && ch_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zrun_q <= '0;
         seen_q <= 1'b0;
      end else if (emit) begin
         if (cbit) begin
            zrun_q <= '0;
            seen_q <= 1'b1;
         end else if (zrun_q != 4'hF) begin
            zrun_q <= zrun_q + 4'd1;
         end
      end else if (idle) begin
         seen_q <= 1'b0;
      end
   end

   AST_RUN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (emit && seen_q && !cbit) |-> (zrun_q < 4'd7)); // R6
   AST_RUN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      (emit && seen_q && cbit) |-> (zrun_q >= 4'd2)); // R6
   AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      wcnt_q <= WCNT_W'(WIN_W)); // R8
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce && ch_valid) |=> (ch_valid && $stable(cbit))); // R8

endmodule

// File: rtl/rll27_framer.sv
module rll27_framer
   import rll27_pkg::*;
#(
   parameter int               CNT_W    = 8,
   parameter int               SYM_W    = 8,
   parameter logic [SYM_W-1:0] GAP_SYM  = SYM_W'('h33),
   parameter logic [SYM_W-1:0] PRE_SYM  = SYM_W'('hFF),
   parameter logic [SYM_W-1:0] SYNC_SYM = SYM_W'('h62),
   parameter logic [SYM_W-1:0] MARK_SYM = SYM_W'('hFE)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] gap_len,
   input  logic [CNT_W-1:0] pre_len,
   input  logic [SYM_W-1:0] s_data,
   input  logic             s_valid,
   input  logic             s_last,
   input  logic             room,
   input  logic             codec_idle,
   output logic             take,
   output logic [SYM_W-1:0] src_byte,
   output logic             s_ready,
   output logic             flush,
   output logic             busy,
   output logic             done
);
   frame_st_t        st_q;
   logic [CNT_W-1:0] cnt_q, pre_q;
   logic             src_valid;

   always_comb begin
      src_valid = 1'b0;
      src_byte  = '0;
      case (st_q)
         ST_GAP:  begin src_valid = 1'b1;    src_byte = GAP_SYM;  end
         ST_PRE:  begin src_valid = 1'b1;    src_byte = PRE_SYM;  end
         ST_SYNC: begin src_valid = 1'b1;    src_byte = SYNC_SYM; end
         ST_MARK: begin src_valid = 1'b1;    src_byte = MARK_SYM; end
         ST_PAY:  begin src_valid = s_valid; src_byte = s_data;   end
         default: ;
      endcase
   end

   assign take    = src_valid && room;
   assign s_ready = (st_q == ST_PAY) && room;
   assign flush   = (st_q == ST_FLUSH);
   assign busy    = (st_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         pre_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st_q)
            ST_IDLE: if (start) begin
               pre_q <= pre_len;
               if (gap_len != '0) begin
                  st_q  <= ST_GAP;
                  cnt_q <= gap_len;
               end else if (pre_len != '0) begin
                  st_q  <= ST_PRE;
                  cnt_q <= pre_len;
               end else begin
                  st_q <= ST_SYNC;
               end
            end
            ST_GAP: if (take) begin
               if (cnt_q == CNT_W'(1)) begin
                  if (pre_q != '0) begin
                     st_q  <= ST_PRE;
                     cnt_q <= pre_q;
                  end else begin
                     st_q <= ST_SYNC;
                  end
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            ST_PRE: if (take) begin
               if (cnt_q == CNT_W'(1)) st_q <= ST_SYNC;
               else                    cnt_q <= cnt_q - CNT_W'(1);
            end
            ST_SYNC:  if (take) st_q <= ST_MARK;
            ST_MARK:  if (take) st_q <= ST_PAY;
            ST_PAY:   if (take && s_last) st_q <= ST_FLUSH;
            ST_FLUSH: if (codec_idle) begin
               st_q <= ST_IDLE;
               done <= 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !take) |=> ($stable(cnt_q) && $stable(pre_q))); // R9

endmodule

// File: rtl/rll27_hdr_enc.sv
module rll27_hdr_enc
   import rll27_pkg::*;
#(
   parameter int               CNT_W      = 8,
   parameter int               SYM_W      = 8,
   parameter logic [SYM_W-1:0] GAP_SYM    = SYM_W'('h33),
   parameter logic [SYM_W-1:0] PRE_SYM    = SYM_W'('hFF),
   parameter logic [SYM_W-1:0] SYNC_SYM   = SYM_W'('h62),
   parameter logic [SYM_W-1:0] MARK_SYM   = SYM_W'('hFE),
   parameter bit               PULSE_HIGH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic             start,
   input  logic [CNT_W-1:0] gap_len,
   input  logic [CNT_W-1:0] pre_len,
   input  logic [SYM_W-1:0] s_data,
   input  logic             s_valid,
   input  logic             s_last,
   output logic             s_ready,
   output logic             wr_pulse,
   output logic             ch_valid,
   output logic             busy,
   output logic             done
);
   if (SYM_W < 4) begin : g_bad_sym
      $error("SYM_W must be at least 4");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic             room, take, flush, codec_idle, cbit;
   logic [SYM_W-1:0] src_byte;

   rll27_framer #(
      .CNT_W(CNT_W), .SYM_W(SYM_W),
      .GAP_SYM(GAP_SYM), .PRE_SYM(PRE_SYM),
      .SYNC_SYM(SYNC_SYM), .MARK_SYM(MARK_SYM)
   ) u_framer (
      .clk(clk), .rst_n(rst_n), .start(start),
      .gap_len(gap_len), .pre_len(pre_len),
      .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
      .room(room), .codec_idle(codec_idle),
      .take(take), .src_byte(src_byte), .s_ready(s_ready),
      .flush(flush), .busy(busy), .done(done)
   );

   rll27_codec #(.SYM_W(SYM_W)) u_codec (
      .clk(clk), .rst_n(rst_n), .ce(ce), .flush(flush),
      .take(take), .src_byte(src_byte), .room(room),
      .cbit(cbit), .ch_valid(ch_valid), .idle(codec_idle)
   );

   if (PULSE_HIGH) begin : g_pos
      assign wr_pulse = ch_valid & cbit;
   end else begin : g_neg
      assign wr_pulse = ~(ch_valid & cbit);
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ch_valid && !s_ready)); // R10
   AST_LAST_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready && s_last) |=> !s_ready); // R7

endmodule

// File: tb/rll27_hdr_enc_test.sv
`timescale 1ns/1ps
module rll27_hdr_enc_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce = 1'b0, start = 1'b0, s_valid = 1'b0, s_last = 1'b0;
   logic [7:0] gap_len = '0, pre_len = '0, s_data = '0;
   logic       s_ready, wr_pulse, ch_valid, busy, done;

   int nchk = 0, nfail = 0;
   bit db [0:4095];
   int nd;
   bit expb [0:8191];
   int exp_n;
   bit actb [0:8191];
   int act_n;
   logic [7:0] pay [0:63];

   always #2 clk = ~clk;

   rll27_hdr_enc uut (
      .clk(clk), .rst_n(rst_n), .ce(ce), .start(start),
      .gap_len(gap_len), .pre_len(pre_len),
      .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
      .s_ready(s_ready), .wr_pulse(wr_pulse), .ch_valid(ch_valid),
      .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic push_byte(input logic [7:0] b);
      for (int k = 7; k >= 0; k--) begin db[nd] = b[k]; nd++; end
   endtask

   task automatic push_str(input string s);
      for (int k = 0; k < s.len(); k++) begin
         expb[exp_n] = (s[k] == 8'h31);
         exp_n++;
      end
   endtask

   function automatic bit dbit(input int i);
      return (i < nd) ? db[i] : 1'b0;
   endfunction

   task automatic build_exp(input int gap, input int pre, input int nb);
      int i;
      nd = 0; exp_n = 0;
      for (int k = 0; k < gap; k++) push_byte(8'h33);
      for (int k = 0; k < pre; k++) push_byte(8'hFF);
      push_byte(8'h62);
      push_byte(8'hFE);
      for (int k = 0; k < nb; k++) push_byte(pay[k]);
      i = 0;
      while (i < nd) begin
         if (dbit(i)) begin
            push_str(dbit(i+1) ? "1000" : "0100");
            i += 2;
         end else if (!dbit(i+1) && dbit(i+2)) begin
            push_str(dbit(i+3) ? "00001000" : "00100100");
            i += 4;
         end else begin
            case ({dbit(i+1), dbit(i+2)})
               2'b00:   push_str("000100");
               2'b10:   push_str("100100");
               default: push_str("001000");
            endcase
            i += 3;
         end
      end
   endtask

   function automatic bit seg_ok(input int off, input string s);
      for (int k = 0; k < s.len(); k++) begin
         if (off + k >= act_n) return 1'b0;
         if (actb[off+k] != (s[k] == 8'h31)) return 1'b0;
      end
      return 1'b1;
   endfunction

   task automatic run_frame(input int gap, input int pre, input int nb,
                            input int ce_pct, input int vld_pct,
                            input bit fixed_pay, input bit restart);
      int  pidx, cyc, mism, firstbad, hold_err, lastp, badrun;
      bit  hs, prev_ce, prev_cv, prev_bit, got_done, ok;
      logic [7:0] fixed [0:3];
      fixed[0] = 8'h01; fixed[1] = 8'h80; fixed[2] = 8'hB6; fixed[3] = 8'h25;
      for (int k = 0; k < nb; k++) pay[k] = fixed_pay ? fixed[k % 4] : 8'($urandom);
      build_exp(gap, pre, nb);
      act_n = 0; hold_err = 0; pidx = 0; cyc = 0; got_done = 0; hs = 0;
      prev_ce = 0; prev_cv = 0; prev_bit = 0;
      @(negedge clk);
      start = 1'b1; gap_len = 8'(gap); pre_len = 8'(pre); s_valid = 1'b0;
      while (!got_done && cyc < 30000) begin
         if (cyc > 0) begin
            @(negedge clk);
            start = 1'b0;
            if (restart && cyc == 40) begin start = 1'b1; gap_len = 8'd7; pre_len = 8'd1; end
            if (prev_cv && !prev_ce && (ch_valid !== 1'b1 || wr_pulse !== prev_bit)) hold_err++;
            if (hs) begin s_valid = 1'b0; pidx++; end
         end
         ce = (int'($urandom % 100) < ce_pct);
         if (pidx < nb && !s_valid && int'($urandom % 100) < vld_pct) begin
            s_valid = 1'b1; s_data = pay[pidx]; s_last = (pidx == nb - 1);
         end
         #1;
         hs = s_valid && s_ready;
         if (ce && ch_valid && act_n < 8192) begin actb[act_n] = wr_pulse; act_n++; end
         prev_ce = ce; prev_cv = ch_valid; prev_bit = wr_pulse;
         got_done = done;
         cyc++;
      end
      chk(got_done, "R7", "done seen", int'(got_done), 1);
      chk(!busy && !ch_valid && !s_ready, "R7", "busy/ch_valid/s_ready with done",
          int'({busy, ch_valid, s_ready}), 0);
      start = 1'b0; s_valid = 1'b0;
      @(negedge clk); #1;
      chk(done == 1'b0, "R7", "done lasts one cycle", int'(done), 0);
      // R1 gap bytes
      ok = 1;
      for (int k = 0; k < gap; k++) if (!seg_ok(k*16, "0000100000001000")) ok = 0;
      chk(ok, "R1", "gap field", gap, gap);
      // R2 preamble bytes
      ok = 1;
      for (int k = 0; k < pre; k++) if (!seg_ok((gap+k)*16, "1000100010001000")) ok = 0;
      chk(ok, "R2", "preamble field", pre, pre);
      chk(seg_ok((gap+pre)*16, "0010000001000100"), "R3", "sync pattern at bit",
          (gap+pre)*16, (gap+pre)*16);
      chk(seg_ok((gap+pre+1)*16, "1000100010000100"), "R4", "mark pattern at bit",
          (gap+pre+1)*16, (gap+pre+1)*16);
      // R5 whole stream
      mism = 0; firstbad = -1;
      for (int k = 0; k < exp_n && k < act_n; k++)
         if (actb[k] != expb[k]) begin mism++; if (firstbad < 0) firstbad = k; end
      chk(mism == 0, "R5", "first mismatching bit index", firstbad, -1);
      chk(act_n == exp_n, "R7", "channel bit count incl. flush padding", act_n, exp_n);
      // R6 run lengths
      lastp = -1; badrun = 0;
      for (int k = 0; k < act_n; k++) if (actb[k]) begin
         if (lastp >= 0 && (k - lastp - 1 < 2 || k - lastp - 1 > 7)) badrun++;
         lastp = k;
      end
      chk(badrun == 0, "R6", "zero runs outside 2..7", badrun, 0);
      chk(hold_err == 0, "R8", "bit changed while ce low", hold_err, 0);
      if (restart)
         chk(mism == 0 && act_n == exp_n, "R9", "stream after ignored start", act_n, exp_n);
   endtask

   initial begin
      #(4 * 190000);
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20250611));
      repeat (3) @(negedge clk);
      #1;
      chk({busy, ch_valid, s_ready, done, wr_pulse} == 5'b0, "R10", "outputs in reset",
          int'({busy, ch_valid, s_ready, done, wr_pulse}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk({busy, ch_valid, s_ready, done, wr_pulse} == 5'b0, "R10", "outputs after reset",
          int'({busy, ch_valid, s_ready, done, wr_pulse}), 0);
      run_frame(2, 3, 4, 100, 100, 1'b1, 1'b0);
      run_frame(0, 0, 1, 100, 100, 1'b0, 1'b0);
      run_frame(1, 0, 3, 40, 30, 1'b0, 1'b1);
      run_frame(0, 2, 8, 60, 10, 1'b1, 1'b0);
      for (int n = 0; n < 6; n++)
         run_frame(int'($urandom % 13), int'($urandom % 13), 1 + int'($urandom % 24),
                   30 + int'($urandom % 71), 20 + int'($urandom % 81), 1'b0, n[0]);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule